// File: doc/BRIEF.md
# Two-dimensional transfer sequencer

This block moves or fills a rectangular window of 32-bit pixels in memory. Software programs a small register file with the window geometry: a source and a destination base address, a width and a height in pixels, and a per-line skip for each side. The skip lets either window sit inside a wider image. Software then sets a start bit. The sequencer walks the window row by row and issues single-word requests on a simple master port that uses a valid/ready handshake.

There are two modes. In fill mode every destination pixel receives one colour held in a register, and the source side is never read. In copy mode each pixel is read from the source window and written to the same row and column of the destination window. Three sticky flags report the end of a transfer, the completion of a chosen destination line, and a bus error. Each flag has its own enable, and the enabled flags share one interrupt line.

While a transfer runs it can be paused and resumed, or cancelled. A programmable number of idle cycles between accesses limits how much bandwidth the block takes.

Top module: `rect_xfer_seq`

## Requirements
- R1: After reset the block is idle. STATUS (word 1) reads 0, no request is raised and `irq` is low.
- R2: Fill mode is CTRL (word 0) bit1 = 0. In this mode every pixel of the destination window is written with COLOR (word 7), and no read request is made.
- R3: Copy mode is CTRL bit1 = 1. In this mode the pixel at row y, column x is read from SRC + 4·(y·(W+Ss)+x) and written to DST + 4·(y·(W+Sd)+x). AREA (word 5) gives W in [15:0] and H in [31:16]. SKIP (word 6) gives Ss in [15:0] and Sd in [31:16], both counted in pixels. Words outside the destination window are not changed.
- R4: A raised request keeps the same address, direction and data until `mem_ready` is seen.
- R5: Let G be GAP (word 9) [7:0]. After each accepted access, `mem_req` stays low for exactly G+1 cycles before the next request rises, unless the transfer is paused.
- R6: Accepting the write of the last pixel sets STATUS bit0 and clears busy (STATUS bit8). Writing a start with W = 0 or H = 0 sets bit0 at once and makes no access.
- R7: STATUS bit1 is set when the last pixel of destination row L is written, where L is MARK (word 8) [15:0] and rows count from 0. It stays clear if L ≥ H.
- R8: When `mem_err` is high with `mem_ready`, STATUS bit2 is set, that access has no effect, busy clears and no further request follows.
- R9: While CTRL bit2 (pause) is 1, no new request starts and busy stays set. Clearing the bit resumes the transfer at the next pixel, and the finished window matches an uninterrupted run.
- R10: Writing CTRL with bit3 (cancel) set during a transfer returns the block to idle at the next access boundary. Bit0 is not set and no further request follows.
- R11: A start (CTRL bit0) written while busy is ignored. Changes to the geometry, mode or colour registers during a transfer do not affect the transfer in progress.
- R12: Writing 1 to a STATUS flag bit clears it and writing 0 leaves it unchanged. `irq` is the OR of the flags gated by IEN (word 2) bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| mem_req | output | 1 | Access request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_err | input | 1 | Accepted access failed |
| irq | output | 1 | Enabled-flag interrupt |

## Verification
The hardest cases to reach are a pause, a cancel or a second start that arrives in the middle of a window while the handshake is stalling. Such a request must take effect at an access boundary and never cut off a request that is still pending. The bench stalls `mem_ready` in a fixed pattern and counts accepted writes. It waits until a chosen number of pixels have landed and then writes the control register. After that it compares the whole memory image, and the access counts, with values computed from the geometry.

// File: rtl/rect_xfer_pkg.sv
package rect_xfer_pkg;
    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int CW     = 16;
    localparam int GW     = 8;
    localparam int NFLAG  = 3;
    localparam int PIXB   = DW / 8;

    localparam int F_DONE = 0;
    localparam int F_MARK = 1;
    localparam int F_ERR  = 2;

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_STAT = 4'd1;
    localparam logic [3:0] A_IEN  = 4'd2;
    localparam logic [3:0] A_SRC  = 4'd3;
    localparam logic [3:0] A_DST  = 4'd4;
    localparam logic [3:0] A_AREA = 4'd5;
    localparam logic [3:0] A_SKIP = 4'd6;
    localparam logic [3:0] A_COL  = 4'd7;
    localparam logic [3:0] A_MARK = 4'd8;
    localparam logic [3:0] A_GAP  = 4'd9;

    typedef enum logic [2:0] {S_IDLE, S_NEXT, S_RD, S_WR, S_GAP} seq_state_t;

    typedef struct packed {
        logic          copy;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] width;
        logic [CW-1:0] height;
        logic [CW-1:0] src_skip;
        logic [CW-1:0] dst_skip;
        logic [CW-1:0] mark_line;
        logic [DW-1:0] colour;
        logic [GW-1:0] gap;
    } xfer_cfg_t;

    function automatic logic [AW-1:0] row_jump(input logic [CW-1:0] skip);
        return (AW'(skip) + AW'(1)) * AW'(PIXB);
    endfunction
endpackage

// File: rtl/rect_xfer_regs.sv
module rect_xfer_regs
    import rect_xfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [3:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             busy,
    input  logic [NFLAG-1:0] evt,
    output xfer_cfg_t        cfg,
    output logic             start_p,
    output logic             abort_p,
    output logic             pause,
    output logic             irq
);
    logic [NFLAG-1:0] flags, ien;
    logic             hit_ctrl, hit_stat;

    assign hit_ctrl = cfg_wr && (cfg_addr == A_CTRL);
    assign hit_stat = cfg_wr && (cfg_addr == A_STAT);
    assign start_p  = hit_ctrl && cfg_wdata[0];
    assign abort_p  = hit_ctrl && cfg_wdata[3];
    assign irq      = |(flags & ien);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            pause <= 1'b0;
            ien   <= '0;
        end else if (cfg_wr) begin
            case (cfg_addr)
                A_CTRL: begin cfg.copy <= cfg_wdata[1]; pause <= cfg_wdata[2]; end
                A_IEN:  ien           <= cfg_wdata[NFLAG-1:0];
                A_SRC:  cfg.src       <= cfg_wdata[AW-1:0];
                A_DST:  cfg.dst       <= cfg_wdata[AW-1:0];
                A_AREA: begin cfg.width <= cfg_wdata[CW-1:0]; cfg.height <= cfg_wdata[16 +: CW]; end
                A_SKIP: begin cfg.src_skip <= cfg_wdata[CW-1:0]; cfg.dst_skip <= cfg_wdata[16 +: CW]; end
                A_COL:  cfg.colour    <= cfg_wdata[DW-1:0];
                A_MARK: cfg.mark_line <= cfg_wdata[CW-1:0];
                A_GAP:  cfg.gap       <= cfg_wdata[GW-1:0];
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                         flags[i] <= 1'b0;
            else if (evt[i])                 flags[i] <= 1'b1;
            else if (hit_stat && cfg_wdata[i]) flags[i] <= 1'b0;
        end
    end

    always_comb begin
        case (cfg_addr)
            A_CTRL:  cfg_rdata = {28'b0, 1'b0, pause, cfg.copy, 1'b0};
            A_STAT:  cfg_rdata = {23'b0, busy, 5'b0, flags};
            A_IEN:   cfg_rdata = 32'(ien);
            A_SRC:   cfg_rdata = 32'(cfg.src);
            A_DST:   cfg_rdata = 32'(cfg.dst);
            A_AREA:  cfg_rdata = {16'(cfg.height), 16'(cfg.width)};
            A_SKIP:  cfg_rdata = {16'(cfg.dst_skip), 16'(cfg.src_skip)};
            A_COL:   cfg_rdata = 32'(cfg.colour);
            A_MARK:  cfg_rdata = 32'(cfg.mark_line);
            A_GAP:   cfg_rdata = 32'(cfg.gap);
            default: cfg_rdata = '0;
        endcase
    end

    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
        (hit_stat && cfg_wdata[F_DONE] && !evt[F_DONE]) |=> !flags[F_DONE]); // R12
    AST_MARK_SET: assert property (@(posedge clk) disable iff (rst)
        evt[F_MARK] |=> flags[F_MARK]); // R7
    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        evt[F_ERR] |=> flags[F_ERR]); // R8
endmodule

// File: rtl/rect_xfer_walker.sv
module rect_xfer_walker
    import rect_xfer_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic          step,
    input  xfer_cfg_t     cfg,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [CW-1:0] row,
    output logic          row_end,
    output logic          last_pix
);
    logic [CW-1:0] col, w_q, h_q, ss_q, ds_q;

    assign row      = row_q_out();
    assign row_end  = (col == w_q - CW'(1));
    assign last_pix = row_end && (row_r == h_q - CW'(1));

    logic [CW-1:0] row_r;
    function automatic logic [CW-1:0] row_q_out();
        return row_r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0; row_r <= '0; w_q <= '0; h_q <= '0; ss_q <= '0; ds_q <= '0;
            src_addr <= '0; dst_addr <= '0;
        end else if (init) begin
            col <= '0; row_r <= '0;
            w_q <= cfg.width; h_q <= cfg.height;
            ss_q <= cfg.src_skip; ds_q <= cfg.dst_skip;
            src_addr <= cfg.src; dst_addr <= cfg.dst;
        end else if (step) begin
            if (row_end) begin
                col      <= '0;
                row_r    <= row_r + CW'(1);
                src_addr <= src_addr + row_jump(ss_q);
                dst_addr <= dst_addr + row_jump(ds_q);
            end else begin
                col      <= col + CW'(1);
                src_addr <= src_addr + AW'(PIXB);
                dst_addr <= dst_addr + AW'(PIXB);
            end
        end
    end

    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (w_q != '0) |-> (col < w_q)); // R3
    AST_STEP_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && row_end && !init) |=> (col == '0)); // R3
endmodule

// File: rtl/rect_xfer_ctrl.sv
module rect_xfer_ctrl
    import rect_xfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  xfer_cfg_t        cfg,
    input  logic             start_p,
    input  logic             abort_p,
    input  logic             pause,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ready,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_err,
    output logic             wk_init,
    output logic             wk_step,
    input  logic [AW-1:0]    src_addr,
    input  logic [AW-1:0]    dst_addr,
    input  logic [CW-1:0]    row,
    input  logic             row_end,
    input  logic             last_pix,
    output logic             busy,
    output logic [NFLAG-1:0] evt
);
    seq_state_t    state;
    logic          have, abort_pend, copy_q;
    logic [DW-1:0] pix, colour_q;
    logic [GW-1:0] gap_q, gcnt;
    logic [CW-1:0] mark_q;
    logic          area_ok, acc_ok, wr_ok;
    seq_state_t    post;

    assign area_ok   = (cfg.width != '0) && (cfg.height != '0);
    assign busy      = (state != S_IDLE);
    assign mem_req   = (state == S_RD) || (state == S_WR);
    assign mem_we    = (state == S_WR);
    assign mem_addr  = mem_we ? dst_addr : src_addr;
    assign mem_wdata = copy_q ? pix : colour_q;
    assign acc_ok    = mem_req && mem_ready && !mem_err;
    assign wr_ok     = acc_ok && mem_we;
    assign wk_init   = (state == S_IDLE) && start_p && area_ok;
    assign wk_step   = wr_ok;
    assign post      = (gap_q == '0) ? S_NEXT : S_GAP;

    always_comb begin
        evt         = '0;
        evt[F_DONE] = ((state == S_IDLE) && start_p && !area_ok) || (wr_ok && last_pix);
        evt[F_MARK] = wr_ok && row_end && (row == mark_q);
        evt[F_ERR]  = mem_req && mem_ready && mem_err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE; have <= 1'b0; abort_pend <= 1'b0; copy_q <= 1'b0;
            pix <= '0; colour_q <= '0; gap_q <= '0; gcnt <= '0; mark_q <= '0;
        end else begin
            abort_pend <= busy && (abort_pend || abort_p);
            case (state)
                S_IDLE: if (wk_init) begin
                    state    <= S_NEXT;
                    have     <= 1'b0;
                    copy_q   <= cfg.copy;
                    colour_q <= cfg.colour;
                    gap_q    <= cfg.gap;
                    mark_q   <= cfg.mark_line;
                end
                S_NEXT: begin
                    if (abort_pend)  state <= S_IDLE;
                    else if (!pause) state <= (copy_q && !have) ? S_RD : S_WR;
                end
                S_GAP: begin
                    gcnt <= gcnt - GW'(1);
                    if (abort_pend)          state <= S_IDLE;
                    else if (gcnt == GW'(1)) state <= S_NEXT;
                end
                S_RD: if (mem_ready) begin
                    if (mem_err || abort_pend) state <= S_IDLE;
                    else begin
                        pix   <= mem_rdata;
                        have  <= 1'b1;
                        gcnt  <= gap_q;
                        state <= post;
                    end
                end
                S_WR: if (mem_ready) begin
                    have <= 1'b0;
                    if (mem_err || last_pix || abort_pend) state <= S_IDLE;
                    else begin
                        gcnt  <= gap_q;
                        state <= post;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R4
    AST_FILL_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !copy_q) |-> mem_we); // R2
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R3
    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((state == S_NEXT) && pause && !abort_pend) |=> (!mem_req && busy)); // R9
    AST_ERR_STOP: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && mem_err) |=> !busy); // R8
    AST_ABORT_EXIT: assert property (@(posedge clk) disable iff (rst)
        (abort_pend && ((state == S_GAP) || (state == S_NEXT))) |=> !busy); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R1
endmodule

// File: rtl/rect_xfer_seq.sv
module rect_xfer_seq
    import rect_xfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [3:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    input  logic        mem_err,
    output logic        irq
);
    xfer_cfg_t        cfg;
    logic             start_p, abort_p, pause, busy, wk_init, wk_step, row_end, last_pix;
    logic [NFLAG-1:0] evt;
    logic [AW-1:0]    src_addr, dst_addr;
    logic [CW-1:0]    row;

    rect_xfer_regs regs_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .evt(evt),
        .cfg(cfg), .start_p(start_p), .abort_p(abort_p), .pause(pause), .irq(irq)
    );

    rect_xfer_walker walk_i (
        .clk(clk), .rst(rst), .init(wk_init), .step(wk_step), .cfg(cfg),
        .src_addr(src_addr), .dst_addr(dst_addr), .row(row),
        .row_end(row_end), .last_pix(last_pix)
    );

    rect_xfer_ctrl ctrl_i (
        .clk(clk), .rst(rst), .cfg(cfg), .start_p(start_p), .abort_p(abort_p),
        .pause(pause), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .wk_init(wk_init), .wk_step(wk_step),
        .src_addr(src_addr), .dst_addr(dst_addr), .row(row), .row_end(row_end),
        .last_pix(last_pix), .busy(busy), .evt(evt)
    );
endmodule

// File: tb/rect_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module rect_xfer_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata, mem_addr, mem_wdata, mem_rdata;
    logic        mem_req, mem_we, mem_ready, mem_err, irq;

    always #2.5 clk = ~clk;

    rect_xfer_seq dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err), .irq(irq)
    );

    // mode, src word, dst word, width, height, src skip, dst skip, gap
    localparam logic [63:0] VEC [5] = '{
        {8'd0, 8'd0,  8'd100, 8'd4, 8'd3, 8'd0, 8'd2, 8'd0},
        {8'd1, 8'd10, 8'd150, 8'd3, 8'd4, 8'd1, 8'd3, 8'd2},
        {8'd1, 8'd40, 8'd200, 8'd5, 8'd2, 8'd0, 8'd0, 8'd0},
        {8'd0, 8'd0,  8'd60,  8'd1, 8'd5, 8'd0, 8'd3, 8'd3},
        {8'd1, 8'd0,  8'd120, 8'd8, 8'd1, 8'd5, 8'd0, 8'd1}
    };

    logic [31:0] mem [256];
    logic [31:0] expm [256];
    int   cyc = 0, wr_cnt = 0, rd_cnt = 0, min_idle = 0, max_idle = 0, hold_bad = 0, last_acc = 0, idl;
    logic have_acc = 1'b0, prev_req = 1'b0, prev_ready = 1'b0, prev_we = 1'b0;
    logic [31:0] prev_addr = '0;
    logic load = 1'b0, clr = 1'b0, err_arm = 1'b0;
    logic [7:0] seed = 8'h00, err_word = 8'h00;
    int checks = 0, fails = 0;

    function automatic logic [31:0] pat(input int i, input logic [7:0] s);
        return {s, 8'(i), ~8'(i), 8'h5A};
    endfunction

    assign mem_ready = mem_req && (cyc[1:0] != 2'd3);
    assign mem_err   = mem_req && err_arm && (mem_addr[9:2] == err_word);
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (load) for (int i = 0; i < 256; i++) mem[i] <= pat(i, seed);
        if (clr) begin
            wr_cnt <= 0; rd_cnt <= 0; min_idle <= 1000; max_idle <= 0;
            have_acc <= 1'b0; hold_bad <= 0;
        end else begin
            if (mem_req && mem_ready && !mem_err) begin
                if (mem_we) begin mem[mem_addr[9:2]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
                else rd_cnt <= rd_cnt + 1;
            end
            if (mem_req && mem_ready) begin last_acc <= cyc; have_acc <= 1'b1; end
            if (mem_req && !prev_req && have_acc) begin
                idl = cyc - last_acc - 1;
                if (idl < min_idle) min_idle <= idl;
                if (idl > max_idle) max_idle <= idl;
            end
            if (prev_req && !prev_ready && (!mem_req || mem_addr != prev_addr || mem_we != prev_we))
                hold_bad <= hold_bad + 1;
        end
        prev_req <= mem_req; prev_ready <= mem_ready; prev_addr <= mem_addr; prev_we <= mem_we;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint ex);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, ex);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        cfg_addr = a; #0.5; d = cfg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk); rd(4'd1, s);
            if (!s[8]) break;
        end
    endtask

    task automatic prep(input logic [7:0] sd);
        @(negedge clk); seed = sd; load = 1'b1; clr = 1'b1;
        @(negedge clk); load = 1'b0; clr = 1'b0;
        for (int i = 0; i < 256; i++) expm[i] = pat(i, sd);
    endtask

    function automatic int mism();
        int m = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) m++;
        return m;
    endfunction

    task automatic setup(input bit cp, input int s, input int d, input int w, input int h,
                         input int ss, input int ds, input int g, input logic [31:0] col, input int mk);
        wr(4'd1, 32'h7); wr(4'd2, 32'h1);
        wr(4'd3, 32'(s * 4)); wr(4'd4, 32'(d * 4));
        wr(4'd5, {16'(h), 16'(w)}); wr(4'd6, {16'(ds), 16'(ss)});
        wr(4'd7, col); wr(4'd8, 32'(mk)); wr(4'd9, 32'(g));
        wr(4'd0, {30'b0, cp, 1'b0});
    endtask

    task automatic expect_area(input bit cp, input int s, input int d, input int w, input int h,
                               input int ss, input int ds, input logic [31:0] col);
        for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++)
                expm[d + y * (w + ds) + x] = cp ? pat(s + y * (w + ss) + x, seed) : col;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] st;
        int w0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(4'd1, st);
        chk(st == 0 && !irq && !mem_req, "R1 reset state", {st, 3'b0, irq}, 0);

        // vector table
        for (int k = 0; k < 5; k++) begin
            logic [63:0] v;
            int cp, s, d, w, h, ss, ds, g, acc;
            v = VEC[k];
            cp = int'(v[63:56]); s = int'(v[55:48]); d = int'(v[47:40]); w = int'(v[39:32]);
            h = int'(v[31:24]); ss = int'(v[23:16]); ds = int'(v[15:8]); g = int'(v[7:0]);
            prep(8'(k + 1));
            setup(cp[0], s, d, w, h, ss, ds, g, 32'hC0DE_0000 | 32'(k), h - 1);
            expect_area(cp[0], s, d, w, h, ss, ds, 32'hC0DE_0000 | 32'(k));
            wr(4'd0, {30'b0, cp[0], 1'b1});
            wait_idle();
            rd(4'd1, st);
            chk(mism() == 0, cp ? "R3 copy image" : "R2 fill image", mism(), 0);
            chk(wr_cnt == w * h, "R6 write count", wr_cnt, w * h);
            chk(rd_cnt == (cp ? w * h : 0), cp ? "R3 read count" : "R2 no reads", rd_cnt, cp ? w * h : 0);
            chk(st[2:0] == 3'b011 && !st[8], "R6 R7 done and mark flags", st, 32'h3);
            chk(irq == 1'b1, "R12 irq with done enabled", irq, 1);
            chk(hold_bad == 0, "R4 request hold", hold_bad, 0);
            acc = cp ? 2 * w * h : w * h;
            if (acc > 1)
                chk(min_idle == g + 1 && max_idle == g + 1, "R5 idle gap", {min_idle, max_idle}, g + 1);
        end

        // R7: mark line beyond height stays clear
        prep(8'h20);
        setup(1'b0, 0, 30, 2, 2, 0, 0, 0, 32'h1111_2222, 5);
        wr(4'd0, 32'h1);
        wait_idle(); rd(4'd1, st);
        chk(st[1] == 1'b0 && st[0] == 1'b1, "R7 mark out of range", st, 1);

        // R6: zero-size area
        prep(8'h21);
        setup(1'b0, 0, 30, 0, 3, 0, 0, 0, 32'h1, 0);
        wr(4'd0, 32'h1);
        repeat (5) @(negedge clk); rd(4'd1, st);
        chk(st[0] && !st[8] && wr_cnt == 0 && rd_cnt == 0, "R6 zero area", {st, wr_cnt}, 1);

        // R12: enables and write-1-to-clear
        wr(4'd2, 32'h0); @(negedge clk);
        chk(irq == 1'b0, "R12 irq masked", irq, 0);
        wr(4'd2, 32'h1); @(negedge clk);
        chk(irq == 1'b1, "R12 irq enabled", irq, 1);
        wr(4'd1, 32'h0); rd(4'd1, st);
        chk(st[0] == 1'b1, "R12 write 0 keeps flag", st, 1);
        wr(4'd1, 32'h1); rd(4'd1, st);
        chk(st[0] == 1'b0 && irq == 1'b0, "R12 write 1 clears flag", {st, 3'b0, irq}, 0);

        // R8: bus error on third write
        prep(8'h22);
        setup(1'b1, 0, 100, 4, 2, 0, 0, 0, 32'h0, 9);
        err_word = 8'd102; err_arm = 1'b1;
        wr(4'd0, 32'h3);
        wait_idle(); repeat (10) @(negedge clk);
        rd(4'd1, st); err_arm = 1'b0;
        chk(st[2] && !st[0] && !st[8], "R8 error flag and stop", st, 32'h4);
        chk(wr_cnt == 2 && rd_cnt == 3, "R8 no access after error", {wr_cnt, rd_cnt}, {32'd2, 32'd3});

        // R9: pause and resume
        prep(8'h23);
        setup(1'b0, 0, 30, 4, 4, 0, 1, 0, 32'hAB12_CD34, 9);
        expect_area(1'b0, 0, 30, 4, 4, 0, 1, 32'hAB12_CD34);
        wr(4'd0, 32'h1);
        while (wr_cnt < 3) @(negedge clk);
        wr(4'd0, 32'h4);
        repeat (20) @(negedge clk);
        w0 = wr_cnt;
        repeat (30) @(negedge clk);
        rd(4'd1, st);
        chk(wr_cnt == w0 && !mem_req && st[8], "R9 paused", {wr_cnt, 31'b0, st[8]}, {w0, 32'h1});
        wr(4'd0, 32'h0);
        wait_idle();
        chk(mism() == 0 && wr_cnt == 16, "R9 resumed image", {mism(), wr_cnt}, 16);

        // R10: cancel
        prep(8'h24);
        setup(1'b0, 0, 100, 8, 8, 0, 0, 2, 32'h5555_AAAA, 99);
        wr(4'd0, 32'h1);
        while (wr_cnt < 5) @(negedge clk);
        wr(4'd0, 32'h8);
        repeat (10) @(negedge clk);
        rd(4'd1, st); w0 = wr_cnt;
        chk(!st[8] && !st[0] && w0 < 64, "R10 cancel to idle", {st, w0}, 0);
        repeat (20) @(negedge clk);
        chk(wr_cnt == w0 && !mem_req, "R10 no access after cancel", wr_cnt, w0);

        // R11: start and reconfiguration while busy
        prep(8'h25);
        setup(1'b0, 0, 40, 4, 4, 0, 0, 3, 32'h7777_0001, 9);
        expect_area(1'b0, 0, 40, 4, 4, 0, 0, 32'h7777_0001);
        wr(4'd0, 32'h1);
        while (wr_cnt < 2) @(negedge clk);
        wr(4'd4, 32'(200 * 4)); wr(4'd7, 32'h9999_0002); wr(4'd5, {16'd2, 16'd2});
        wr(4'd0, 32'h3);
        wait_idle();
        chk(mism() == 0, "R11 image unchanged by mid-run writes", mism(), 0);
        chk(wr_cnt == 16 && rd_cnt == 0, "R11 start ignored", {wr_cnt, rd_cnt}, {32'd16, 32'd0});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule